// File: doc/BRIEF.md
# VLAN Membership Table with Hardware Search

This block keeps the VLAN membership table of a small Ethernet switch with up to twelve ports. Every one of the 4096 VLAN IDs owns one table slot. A slot holds a valid flag, a forwarding-database number, a spanning-tree group number and a two-bit membership code for each port. A host reaches the table only through seven 16-bit registers. It stages a VLAN ID and its entry contents in those registers, then writes a command word whose top bit marks the operation as started.

Three commands act on the table. Flush invalidates every slot. Load writes one slot, and a load whose valid flag is clear purges that slot. Search walks upward from a starting VLAN ID, one slot per clock, and returns the next valid VLAN with its contents unpacked into the staging registers. The host polls the busy bit to learn when a command has finished.

Register map (word addresses): 0 command, 1 VLAN ID, 2/3/4 membership words, 5 forwarding-database number, 6 spanning-tree group.

Top module: `vtu_top`

## Requirements
- R1: The command register (address 0) holds busy in bit 15 and a 3-bit opcode in bits 14:12. A write with bit 15 set starts the opcode. Busy then reads 1 until the command has finished, and the last started opcode reads back in bits 14:12.
- R2: Reset sets every register to zero and starts a flush, so the command register reads 0x8000 until all 4096 slots are invalid. The table is empty afterwards.
- R3: Opcode 1 (flush) invalidates every slot, so a later search from VLAN 0 finds nothing.
- R4: Opcode 3 (load) writes the slot named by VID register bits 11:0. It takes the valid flag from VID bit 12 and the contents from the membership, database and group registers. A load with bit 12 clear purges the slot, and searches skip it.
- R5: Opcode 4 (search) finds the lowest valid VLAN strictly above VID bits 11:0. It writes that VLAN to the VID register with bit 12 set, the database number to register 5 bits 11:0, and the group number to register 6 bits 5:0.
- R6: Port i's 2-bit code sits in membership word 2+i/4 at bits (i mod 4)*4+1:(i mod 4)*4. The codes are 0 member unmodified, 1 member untagged, 2 member tagged and 3 non-member. A search returns each code unchanged and clears the other bits of the membership words.
- R7: A search that finds nothing writes 0x0FFF to the VID register and leaves the membership, database and group registers unchanged. A search from 4095 always finds nothing.
- R8: While busy is set, host writes to any register are ignored, including a new command.
- R9: Opcodes 0, 2, 5, 6 and 7 finish without changing the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |

## Verification
A valid flag that is wrong or stale shows up at the next search. The search either stops on the wrong VLAN or returns 0x0FFF, and it finishes a number of cycles later that matches the gap it walked. A fault in the membership packing shows in the three membership words as soon as a search completes, so entries mix all four codes across the port positions. A busy flag that drops early, or a write accepted while busy, is caught by reading the staged registers right after the long searches. The bench injects writes into those searches on purpose.

// File: rtl/vtu_pkg.sv
package vtu_pkg;
   localparam int REG_W = 16;

   localparam logic [2:0] A_CMD = 3'd0;
   localparam logic [2:0] A_VID = 3'd1;
   localparam logic [2:0] A_MB0 = 3'd2;
   localparam logic [2:0] A_MB1 = 3'd3;
   localparam logic [2:0] A_MB2 = 3'd4;
   localparam logic [2:0] A_FDB = 3'd5;
   localparam logic [2:0] A_STG = 3'd6;

   localparam logic [2:0] OPC_FLUSH = 3'd1;
   localparam logic [2:0] OPC_LOAD  = 3'd3;
   localparam logic [2:0] OPC_NEXT  = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_LOAD,
      ST_SCAN,
      ST_NOP
   } eng_state_t;
endpackage

// File: rtl/vtu_store.sv
module vtu_store #(
   parameter int AW = 12,
   parameter int EW = 42
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wvalid,
   input  logic [EW-1:0] wentry,
   input  logic [AW-1:0] raddr,
   output logic          rvalid,
   output logic [EW-1:0] rentry
);
   localparam int DEPTH = 1 << AW;

   logic          vmem [DEPTH];
   logic [EW-1:0] emem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         vmem[waddr] <= wvalid;
         emem[waddr] <= wentry;
      end
   end

   assign rvalid = vmem[raddr];
   assign rentry = emem[raddr];
endmodule

// File: rtl/vtu_engine.sv
module vtu_engine
   import vtu_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    op,
   input  logic [AW-1:0] vid,
   input  logic          rvalid,
   output logic          busy,
   output logic [AW-1:0] cur_addr,
   output logic          we,
   output logic          wsel_load,
   output logic [AW-1:0] waddr,
   output logic          upd,
   output logic          found,
   output logic [AW-1:0] hit_vid
);
   localparam int DEPTH = 1 << AW;

   eng_state_t    state_q;
   logic [AW:0]   cur_q;

   assign busy     = (state_q != ST_IDLE);
   assign cur_addr = cur_q[AW-1:0];
   assign hit_vid  = cur_q[AW-1:0];

   always_comb begin
      we        = 1'b0;
      wsel_load = 1'b0;
      waddr     = cur_q[AW-1:0];
      upd       = 1'b0;
      found     = 1'b0;
      case (state_q)
         ST_FLUSH: we = 1'b1;
         ST_LOAD: begin
            we        = 1'b1;
            wsel_load = 1'b1;
            waddr     = vid;
         end
         ST_SCAN: begin
            if (cur_q[AW]) begin
               upd = 1'b1;
            end else if (rvalid) begin
               upd   = 1'b1;
               found = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FLUSH;
         cur_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  case (op)
                     OPC_FLUSH: begin
                        state_q <= ST_FLUSH;
                        cur_q   <= '0;
                     end
                     OPC_LOAD: state_q <= ST_LOAD;
                     OPC_NEXT: begin
                        state_q <= ST_SCAN;
                        cur_q   <= {1'b0, vid} + 1'b1;
                     end
                     default: state_q <= ST_NOP;
                  endcase
               end
            end
            ST_FLUSH: begin
               if (&cur_q[AW-1:0]) state_q <= ST_IDLE;
               else                cur_q   <= cur_q + 1'b1;
            end
            ST_SCAN: begin
               if (upd) state_q <= ST_IDLE;
               else     cur_q   <= cur_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: an accepted command raises busy on the next cycle
   p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R3: the sweep ends right after the last slot is cleared
   p_flush_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FLUSH && (&cur_q[AW-1:0])) |=> !busy);
   // R5: the search advances exactly one slot per idle step
   p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCAN && !upd) |=> (cur_q == $past(cur_q) + 1'b1));
   // R7: the cursor never runs past the end of the VLAN space
   p_scan_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SCAN) |-> (cur_q <= (AW+1)'(DEPTH)));
endmodule

// File: rtl/vtu_regfile.sv
module vtu_regfile
   import vtu_pkg::*;
#(
   parameter int VID_W  = 12,
   parameter int NPORTS = 12,
   parameter int FID_W  = 12,
   parameter int SID_W  = 6,
   localparam int MW    = 2 * NPORTS,
   localparam int EW    = MW + SID_W + FID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [2:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             busy,
   input  logic             upd,
   input  logic             found,
   input  logic [VID_W-1:0] hit_vid,
   input  logic [EW-1:0]    hit_entry,
   output logic             start,
   output logic [2:0]       op_code,
   output logic [VID_W:0]   vid_q,
   output logic [EW-1:0]    ld_entry
);
   localparam int NWORDS = 3;
   localparam int PPW    = 4;

   if (NPORTS < 1 || NPORTS > NWORDS * PPW) begin : g_bad_ports
      $error("vtu_regfile: NPORTS out of range");
   end
   if (VID_W + 1 > REG_W || FID_W > REG_W || SID_W > REG_W) begin : g_bad_width
      $error("vtu_regfile: field wider than a register");
   end

   logic [2:0]              op_q;
   logic [NWORDS*REG_W-1:0] mb_q;
   logic [FID_W-1:0]        fid_q;
   logic [SID_W-1:0]        sid_q;
   logic [NWORDS*REG_W-1:0] hit_pk;
   logic [MW-1:0]           ld_mbr;
   logic [MW-1:0]           hit_mbr;

   assign hit_mbr = hit_entry[FID_W+SID_W +: MW];

   for (genvar p = 0; p < NWORDS * PPW; p++) begin : g_port
      if (p < NPORTS) begin : g_live
         assign hit_pk[p*4 +: 4] = {2'b00, hit_mbr[2*p +: 2]};
         assign ld_mbr[2*p +: 2] = mb_q[p*4 +: 2];
      end else begin : g_pad
         assign hit_pk[p*4 +: 4] = 4'b0000;
      end
   end

   assign start    = wr && !busy && (addr == A_CMD) && wdata[REG_W-1];
   assign op_code  = wdata[14:12];
   assign ld_entry = {ld_mbr, sid_q, fid_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= '0;
         vid_q <= '0;
         mb_q  <= '0;
         fid_q <= '0;
         sid_q <= '0;
      end else if (upd) begin
         if (found) begin
            vid_q <= {1'b1, hit_vid};
            mb_q  <= hit_pk;
            fid_q <= hit_entry[FID_W-1:0];
            sid_q <= hit_entry[FID_W +: SID_W];
         end else begin
            vid_q <= {1'b0, {VID_W{1'b1}}};
         end
      end else if (wr && !busy) begin
         case (addr)
            A_CMD: if (wdata[REG_W-1]) op_q <= wdata[14:12];
            A_VID: vid_q <= wdata[VID_W:0];
            A_MB0: mb_q[0*REG_W +: REG_W] <= wdata;
            A_MB1: mb_q[1*REG_W +: REG_W] <= wdata;
            A_MB2: mb_q[2*REG_W +: REG_W] <= wdata;
            A_FDB: fid_q <= wdata[FID_W-1:0];
            A_STG: sid_q <= wdata[SID_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         A_CMD:   rdata = {busy, op_q, 12'h000};
         A_VID:   rdata = REG_W'(vid_q);
         A_MB0:   rdata = mb_q[0*REG_W +: REG_W];
         A_MB1:   rdata = mb_q[1*REG_W +: REG_W];
         A_MB2:   rdata = mb_q[2*REG_W +: REG_W];
         A_FDB:   rdata = REG_W'(fid_q);
         A_STG:   rdata = REG_W'(sid_q);
         default: rdata = '0;
      endcase
   end

   // R7: a miss leaves the end-of-space code with valid clear
   p_miss_vid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !found) |=> (vid_q == {1'b0, {VID_W{1'b1}}}));
   // R5: a hit always reports the valid flag
   p_hit_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && found) |=> vid_q[VID_W]);
   // R8: host writes during a command leave the staged fields alone
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr && !upd) |=> ($stable(fid_q) && $stable(sid_q) && $stable(vid_q)));
endmodule

// File: rtl/vtu_top.sv
module vtu_top
   import vtu_pkg::*;
#(
   parameter int VID_W  = 12,
   parameter int NPORTS = 12,
   parameter int FID_W  = 12,
   parameter int SID_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   localparam int MW = 2 * NPORTS;
   localparam int EW = MW + SID_W + FID_W;

   logic             busy, start, upd, found, we, wsel_load, rvalid;
   logic [2:0]       op_code;
   logic [VID_W:0]   vid_q;
   logic [VID_W-1:0] cur_addr, waddr, hit_vid;
   logic [EW-1:0]    ld_entry, rentry, wentry;
   logic             wvalid;

   assign wvalid = wsel_load ? vid_q[VID_W] : 1'b0;
   assign wentry = wsel_load ? ld_entry : '0;

   vtu_regfile #(.VID_W(VID_W), .NPORTS(NPORTS), .FID_W(FID_W), .SID_W(SID_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(busy), .upd(upd), .found(found), .hit_vid(hit_vid),
      .hit_entry(rentry), .start(start), .op_code(op_code), .vid_q(vid_q),
      .ld_entry(ld_entry)
   );

   vtu_engine #(.AW(VID_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_code), .vid(vid_q[VID_W-1:0]),
      .rvalid(rvalid), .busy(busy), .cur_addr(cur_addr), .we(we),
      .wsel_load(wsel_load), .waddr(waddr), .upd(upd), .found(found),
      .hit_vid(hit_vid)
   );

   vtu_store #(.AW(VID_W), .EW(EW)) u_mem (
      .clk(clk), .we(we), .waddr(waddr), .wvalid(wvalid), .wentry(wentry),
      .raddr(cur_addr), .rvalid(rvalid), .rentry(rentry)
   );
endmodule

// File: tb/sim_vtu_top.sv
`timescale 1ns/1ps
module sim_vtu_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;

   vtu_top u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   always #10 clk = ~clk;

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic [2:0]  a;
      logic [15:0] e;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   bit          mv [4096];
   logic [11:0] mf [4096];
   logic [5:0]  ms [4096];
   logic [23:0] mm [4096];
   logic [15:0] e_vid, e_fid, e_sid;
   logic [15:0] e_d [3];

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected reads and compares them
   always @(negedge clk) begin
      exp_t it;
      #2;
      if (sbq.size() > 0) begin
         it = sbq.pop_front();
         chk(reg_rdata, it.e, it.tag);
      end
   end

   function automatic logic [15:0] pk(input logic [23:0] m, input int r);
      logic [15:0] v = 16'h0;
      for (int k = 0; k < 4; k++) v[k*4 +: 2] = m[(r*4+k)*2 +: 2];
      return v;
   endfunction

   task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
      @(negedge clk);
      reg_addr = a;
      sbq.push_back('{a, e, tag});
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         reg_addr = 3'd0;
         #1;
         if (!reg_rdata[15]) return;
      end
      checks++; failures++;
      $display("FAIL R1 busy stuck act=1 exp=0");
   endtask

   task automatic load(input logic [11:0] vid, input bit valid, input logic [23:0] m,
                       input logic [11:0] f, input logic [5:0] s);
      wr(1, {3'b000, valid, vid});
      for (int r = 0; r < 3; r++) begin
         wr(3'(2 + r), pk(m, r));
         e_d[r] = pk(m, r);
      end
      wr(5, {4'h0, f});
      wr(6, {10'h0, s});
      wr(0, 16'hB000);
      wait_idle();
      e_vid = {3'b000, valid, vid}; e_fid = {4'h0, f}; e_sid = {10'h0, s};
      mv[vid] = valid; mm[vid] = m; mf[vid] = f; ms[vid] = s;
   endtask

   task automatic getnext(input logic [11:0] from, input bit inject, input string tag);
      int hit;
      wr(1, {4'h0, from});
      wr(0, 16'hC000);
      if (inject) begin
         wr(5, 16'h0555);
         wr(0, 16'h9000);
         wr(1, 16'h0007);
         wr(2, 16'h1111);
      end
      wait_idle();
      hit = -1;
      for (int v = int'(from) + 1; v < 4096; v++) begin
         if (mv[v]) begin hit = v; break; end
      end
      if (hit >= 0) begin
         e_vid = 16'h1000 | 16'(hit);
         for (int r = 0; r < 3; r++) e_d[r] = pk(mm[hit], r);
         e_fid = {4'h0, mf[hit]};
         e_sid = {10'h0, ms[hit]};
      end else begin
         e_vid = 16'h0FFF;
      end
      rd(1, e_vid, {tag, " R5 vid"});
      rd(2, e_d[0], {tag, " R6 word0"});
      rd(3, e_d[1], {tag, " R6 word1"});
      rd(4, e_d[2], {tag, " R6 word2"});
      rd(5, e_fid, {tag, " R5 fdb"});
      rd(6, e_sid, {tag, " R5 stg"});
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog R1 act=running exp=done");
      finish_run();
   end

   initial begin
      logic [23:0] m_a;
      for (int i = 0; i < 12; i++) m_a[2*i +: 2] = 2'(i % 4);
      for (int v = 0; v < 4096; v++) mv[v] = 1'b0;
      e_vid = 16'h0; e_fid = 16'h0; e_sid = 16'h0;
      for (int r = 0; r < 3; r++) e_d[r] = 16'h0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(0, 16'h8000, "R2 flush busy after reset");
      rd(1, 16'h0000, "R2 vid cleared");
      rd(2, 16'h0000, "R2 word0 cleared");
      rd(5, 16'h0000, "R2 fdb cleared");
      wait_idle();
      rd(0, 16'h0000, "R1 idle after reset flush");
      getnext(12'd0, 1'b0, "R2 empty table");

      load(12'd5, 1'b1, m_a, 12'hABC, 6'h2A);
      rd(0, 16'h3000, "R1 opcode readback");
      load(12'd100, 1'b1, 24'h555555, 12'h007, 6'h01);
      load(12'd4095, 1'b1, 24'hFFFFFF, 12'hFFF, 6'h3F);
      getnext(12'd0, 1'b0, "R6 mixed codes");
      getnext(12'd5, 1'b0, "R5 strictly above");
      getnext(12'd100, 1'b0, "R5 last slot");
      getnext(12'd4095, 1'b0, "R7 end of space");

      load(12'd100, 1'b0, 24'h0, 12'h0, 6'h0);
      getnext(12'd5, 1'b1, "R4 purge skipped R8 busy writes");
      getnext(12'd0, 1'b0, "R8 flush ignored while busy");

      wr(2, 16'hBEEF); e_d[0] = 16'hBEEF;
      wr(5, 16'h0321); e_fid = 16'h0321;
      load(12'd4095, 1'b0, 24'h0, 12'h0, 6'h0);
      wr(2, 16'hBEEF); e_d[0] = 16'hBEEF;
      getnext(12'd5, 1'b0, "R7 miss keeps staged data");

      wr(0, 16'hF000);
      wait_idle();
      rd(0, 16'h7000, "R9 opcode readback");
      getnext(12'd0, 1'b0, "R9 table unchanged");

      wr(0, 16'h9000);
      rd(0, 16'h9000, "R1 busy during flush");
      wait_idle();
      for (int v = 0; v < 4096; v++) mv[v] = 1'b0;
      getnext(12'd0, 1'b0, "R3 table empty after flush");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule